// File: doc/BRIEF.md
# Dual-Channel High/Low-Count PWM

The block drives two pulse-width-modulated output pins. Each channel forms its waveform from two separate 16-bit lengths: a high phase and a low phase, both counted in prescaled ticks. The output is high for the high length, then low for the low length, and the pattern repeats. A tick comes from one of four clock-enable inputs that the channel selects. A 7-bit prescaler divides that tick, and a gate bit can freeze the count. The block has no polarity control. To get the inverted waveform, software swaps the two lengths.

Software uses a word-addressed register bus. Word 0 holds the phase lengths of channel A and word 1 holds those of channel B (byte offsets 0x0 and 0x4). Word 2 (byte offset 0x8) is one control register shared by both channels: it holds the enables, source selects, prescalers and gates. Lengths written while a channel runs are held back until the next phase boundary, so a period is never cut short. Clearing an enable drops the output at once.

Top module: `pwm2_top`

## Requirements
- R1: After reset, every register reads zero and both PWM outputs are low.
- R2: A write to word address 0, 1 or 2 (byte offsets 0x0, 0x4, 0x8) is captured whole, and a read of that address returns the last value written.
- R3: A phase-length word holds the high length in bits 31:16 and the low length in bits 15:0. In steady state, with a tick on every clock and a prescaler field of 0, the output is high for exactly H clocks and low for exactly L clocks.
- R4: The prescaler field is bits 14:8 for channel A and bits 22:16 for channel B. A field value N makes each phase count last N+1 selected ticks, so phase durations scale by N+1.
- R5: The source select is bits 5:4 for channel A and bits 7:6 for channel B. Value k picks tick input k of that channel. An input that never pulses leaves the output frozen.
- R6: The gate bit is bit 15 for channel A and bit 23 for channel B. While it is clear, the enabled channel does not count and its output holds its level.
- R7: The enable bit is bit 0 for channel A and bit 1 for channel B. When a channel is enabled with a nonzero high length, its output is high in the first cycle after the write, and that first high phase is the full length.
- R8: Clearing a channel's enable bit drives its output low in the first cycle after the write, partway through a phase.
- R9: A zero high length keeps the output low. A zero low length with a nonzero high length keeps it high. Both lengths zero keeps it low.
- R10: Lengths written while a channel runs do not change the phase in progress. The new low length applies from the next low phase, and the new high length applies from the next high phase.
- R11: The channels are independent. Swapping the high and low lengths of a channel produces the complementary duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Word address (0: channel A lengths, 1: channel B lengths, 2: control) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_a | input | 4 | Four candidate tick sources for channel A |
| tick_b | input | 4 | Four candidate tick sources for channel B |
| pwm_out | output | 2 | PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
A wrong phase state or phase count shows at a pin as a high or low run that is one or more ticks too long or too short. It is visible within one period, so the bench measures whole runs rather than single samples. A shadow length that loads too early shows as a shortened phase in the period where the new lengths are written. A faulty prescaler or source mux shows as a run length off by a whole factor. Faults in the enable path show in the cycle right after the control write, as a missing start-high level or an output that does not drop.

// File: rtl/pwm2_pkg.sv
// pwm2_pkg: shared constants, field-position helpers and types for the
// dual-channel high/low-count PWM. Assumes two channels packed into one
// control word, with per-channel field offsets that are linear in the index.
package pwm2_pkg;

    localparam int NUM_CH  = 2;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;

    // Bit position of a channel's run-enable flag in the control word.
    function automatic int run_bit(input int ch);
        return ch;
    endfunction

    // Lowest bit of a channel's tick-source select field.
    function automatic int src_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction

    // Lowest bit of a channel's prescaler field.
    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction

    // Bit position of a channel's count-gate flag.
    function automatic int gate_bit(input int ch);
        return 15 + 8 * ch;
    endfunction

endpackage

// File: rtl/pwm2_regs.sv
// pwm2_regs: register file for the PWM. It holds one phase-length word per
// channel and one shared control word. Assumes single-cycle writes and a
// combinational read of the addressed word. Unmapped addresses read zero and
// ignore writes.
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int D_W    = DATA_W,
    parameter int A_W    = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [A_W-1:0]             addr,
    input  logic [D_W-1:0]             wdata,
    output logic [D_W-1:0]             rdata,
    output logic [N_CH-1:0][D_W-1:0]   lengths_q,
    output logic [D_W-1:0]             ctrl_q
);

    localparam logic [A_W-1:0] CTRL_ADDR = A_W'(N_CH);

    // Capture the per-channel length words.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_len
        localparam logic [A_W-1:0] MY_ADDR = A_W'(ch);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lengths_q[ch] <= '0;
            end else if (wr_en && addr == MY_ADDR) begin
                lengths_q[ch] <= wdata;
            end
        end
    end

    // Capture the shared control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == CTRL_ADDR) begin
            ctrl_q <= wdata;
        end
    end

    // Return the addressed word for a read.
    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            if (addr == A_W'(ch)) begin
                rdata = lengths_q[ch];
            end
        end
        if (addr == CTRL_ADDR) begin
            rdata = ctrl_q;
        end
    end

endmodule

// File: rtl/pwm2_prescale.sv
// pwm2_prescale: picks one of the candidate tick inputs and divides it by
// div+1. The divider counts only while the gate is set. It is held cleared
// while clr is high, so the first divided tick after a start is a full one.
// Assumes the tick inputs are synchronous one-cycle clock enables.
module pwm2_prescale
    import pwm2_pkg::*;
#(
    parameter int P_W   = PRE_W,
    parameter int S_W   = SEL_W,
    localparam int N_S  = 1 << S_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [N_S-1:0]  src,
    input  logic [S_W-1:0]  sel,
    input  logic            gate,
    input  logic [P_W-1:0]  div,
    output logic            ptick
);

    logic [P_W-1:0] pcnt_q;
    logic           picked;
    logic           wrap;

    // Select the chosen tick source.
    always_comb begin
        picked = src[sel];
    end

    // Decide whether this tick ends a divide period.
    always_comb begin
        wrap  = (pcnt_q >= div);
        ptick = !clr && gate && picked && wrap;
    end

    // Advance the divider on gated, selected ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt_q <= '0;
        end else if (gate && picked) begin
            if (wrap) begin
                pcnt_q <= '0;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm2_phase_gen.sv
// pwm2_phase_gen: alternates a high phase and a low phase whose lengths are
// counted in prescaled ticks. Lengths come from shadow copies. The shadows
// follow the registers while the channel is stopped and reload only at phase
// boundaries while it runs. Stopping forces the output low and rearms the
// channel in the high phase with its count cleared.
module pwm2_phase_gen
    import pwm2_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            ptick,
    input  logic [C_W-1:0]  hi_len,
    input  logic [C_W-1:0]  lo_len,
    output logic            pwm
);

    phase_t         phase_q;
    logic [C_W-1:0] cnt_q;
    logic [C_W-1:0] hi_sh_q;
    logic [C_W-1:0] lo_sh_q;
    logic [C_W-1:0] cur_len;
    logic [C_W:0]   cnt_inc;
    logic           phase_done;

    // Work out whether the current phase ends on this tick.
    always_comb begin
        cur_len    = (phase_q == PH_HIGH) ? hi_sh_q : lo_sh_q;
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        phase_done = (cur_len == '0) || (cnt_inc >= {1'b0, cur_len});
    end

    // Step the phase state and reload the shadows at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            hi_sh_q <= '0;
            lo_sh_q <= '0;
        end else if (!run) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            hi_sh_q <= hi_len;
            lo_sh_q <= lo_len;
        end else if (ptick) begin
            if (phase_done) begin
                phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
                cnt_q   <= '0;
                hi_sh_q <= hi_len;
                lo_sh_q <= lo_len;
            end else begin
                cnt_q   <= cnt_inc[C_W-1:0];
            end
        end
    end

    // Drive the pin. A zero high length never shows high. A zero low
    // length keeps the high level through the low phase.
    always_comb begin
        pwm = run && (hi_sh_q != '0) &&
              ((phase_q == PH_HIGH) || (lo_sh_q == '0));
    end

endmodule

// File: rtl/pwm2_top.sv
// pwm2_top: dual-channel PWM. It holds a small register file and, per
// channel, a tick selector/prescaler and a high/low phase generator. Assumes
// a synchronous bus in the clk domain and tick sources that are clock
// enables in that domain.
module pwm2_top
    import pwm2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] tick_a,
    input  logic [NUM_SRC-1:0] tick_b,
    output logic [NUM_CH-1:0]  pwm_out
);

    logic [NUM_CH-1:0][DATA_W-1:0]  lengths_q;
    logic [DATA_W-1:0]              ctrl_q;
    logic [NUM_CH-1:0][NUM_SRC-1:0] src_all;
    logic [NUM_CH-1:0]              run_v;
    logic [NUM_CH-1:0]              gate_v;
    logic [NUM_CH-1:0]              ptick;

    // Gather the tick sources into one array indexed by channel.
    always_comb begin
        src_all[0] = tick_a;
        src_all[1] = tick_b;
    end

    pwm2_regs #(
        .N_CH (NUM_CH),
        .D_W  (DATA_W),
        .A_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .lengths_q (lengths_q),
        .ctrl_q    (ctrl_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int RB = run_bit(ch);
        localparam int SL = src_lsb(ch);
        localparam int DL = div_lsb(ch);
        localparam int GB = gate_bit(ch);

        // Pull this channel's control fields out of the shared word.
        always_comb begin
            run_v[ch]  = ctrl_q[RB];
            gate_v[ch] = ctrl_q[GB];
        end

        pwm2_prescale #(
            .P_W (PRE_W),
            .S_W (SEL_W)
        ) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!ctrl_q[RB]),
            .src   (src_all[ch]),
            .sel   (ctrl_q[SL +: SEL_W]),
            .gate  (ctrl_q[GB]),
            .div   (ctrl_q[DL +: PRE_W]),
            .ptick (ptick[ch])
        );

        pwm2_phase_gen #(
            .C_W (CNT_W)
        ) u_phase (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (ctrl_q[RB]),
            .ptick  (ptick[ch]),
            .hi_len (lengths_q[ch][2*CNT_W-1:CNT_W]),
            .lo_len (lengths_q[ch][CNT_W-1:0]),
            .pwm    (pwm_out[ch])
        );
    end

endmodule

// File: rtl/pwm2_checker.sv
// pwm2_checker: temporal checks on the PWM, bound into pwm2_top. It looks at
// the pins, the bus and the decoded control flags. Assumes the synchronous
// active-low reset of the top.
module pwm2_checker
    import pwm2_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [DATA_W-1:0]         ctrl_q,
    input  logic [NUM_CH-1:0][DATA_W-1:0] lengths_q,
    input  logic [NUM_CH-1:0]         run_v,
    input  logic [NUM_CH-1:0]         gate_v,
    input  logic [NUM_CH-1:0]         ptick,
    input  logic [NUM_CH-1:0]         pwm_out
);

    // R2: a control write is captured whole.
    a_r2_ctrl_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == ADDR_W'(NUM_CH)) |-> ctrl_q == $past(bus_wdata));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R8: a stopped channel drives low in the first cycle after the stop.
        a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run_v[ch]) && !run_v[ch]) |-> !pwm_out[ch]);

        // R7: a start with a nonzero high length shows high at once.
        a_r7_start_high: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(run_v[ch]) && lengths_q[ch][2*CNT_W-1:CNT_W] != '0) |-> pwm_out[ch]);

        // R9: a start with a zero high length stays low.
        a_r9_zero_high_low: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(run_v[ch]) && lengths_q[ch][2*CNT_W-1:CNT_W] == '0) |-> !pwm_out[ch]);

        // R6: with the gate clear the running output keeps its level.
        a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run_v[ch]) && run_v[ch] && !$past(gate_v[ch])) |-> $stable(pwm_out[ch]));

        // R10: a running output changes only after a prescaled tick.
        a_r10_no_midphase_change: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run_v[ch]) && run_v[ch] && !$past(ptick[ch])) |-> $stable(pwm_out[ch]));
    end

endmodule

bind pwm2_top pwm2_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .lengths_q (lengths_q),
    .run_v     (run_v),
    .gate_v    (gate_v),
    .ptick     (ptick),
    .pwm_out   (pwm_out)
);

// File: tb/sim_pwm2_top.sv
// sim_pwm2_top: directed bench for pwm2_top. There is one task per scenario,
// and each task checks its own results at negedge samples.
module sim_pwm2_top;

    localparam int CLK_PERIOD = 10;
    localparam int GUARD      = 4000;

    logic        clk;
    logic        rst_n;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_a;
    logic [3:0]  tick_b;
    logic [1:0]  pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    pwm2_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .pwm_out   (pwm_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick sources: 0 every cycle, 1 every 2nd, 2 every 3rd, 3 never.
    initial begin
        tick_a = 4'b0001;
        tick_b = 4'b0001;
        forever begin
            @(negedge clk);
            cyc++;
            tick_a = {1'b0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
            tick_b = tick_a;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    // Control word built from the field positions stated in R4..R7.
    function automatic logic [31:0] ctl(input bit ea, input bit ga, input int pa, input int sa,
                                        input bit eb, input bit gb, input int pb, input int sb);
        logic [31:0] w;
        w = '0;
        w[0] = ea;  w[15] = ga;  w[14:8]  = pa[6:0]; w[5:4] = sa[1:0];
        w[1] = eb;  w[23] = gb;  w[22:16] = pb[6:0]; w[7:6] = sb[1:0];
        return w;
    endfunction

    function automatic logic [31:0] lens(input int hi, input int lo);
        return {hi[15:0], lo[15:0]};
    endfunction

    // Write one register; call at a negedge, returns at the next negedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    // Measure one clean high run and the low run after it.
    task automatic measure(input int ch, output int hi, output int lo);
        int g;
        g = 0; hi = 0; lo = 0;
        while (pwm_out[ch] !== 1'b0 && g < GUARD) begin @(negedge clk); g++; end
        while (pwm_out[ch] !== 1'b1 && g < GUARD) begin @(negedge clk); g++; end
        while (pwm_out[ch] === 1'b1 && g < GUARD) begin hi++; @(negedge clk); g++; end
        while (pwm_out[ch] === 1'b0 && g < GUARD) begin lo++; @(negedge clk); g++; end
    endtask

    task automatic run_check(input int ch, input int ehi, input int elo, input string tag);
        int h, l;
        measure(ch, h, l);
        check(h == ehi, {tag, " high"}, h, ehi);
        check(l == elo, {tag, " low"}, l, elo);
    endtask

    task automatic hold_check(input int ch, input bit lvl, input int n, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch] !== lvl) bad++;
            @(negedge clk);
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset;
        check(pwm_out === 2'b00, "R1 outputs low", pwm_out, 0);
        rd_check(2'd0, 32'h0, "R1 word0 zero");
        rd_check(2'd1, 32'h0, "R1 word1 zero");
        rd_check(2'd2, 32'h0, "R1 word2 zero");
    endtask

    task automatic t_readback;
        wr(2'd0, 32'hA5C3_1234);
        wr(2'd1, 32'h0F0F_8001);
        wr(2'd2, 32'hFF7C_FFFC);
        rd_check(2'd0, 32'hA5C3_1234, "R2 word0");
        rd_check(2'd1, 32'h0F0F_8001, "R2 word1");
        rd_check(2'd2, 32'hFF7C_FFFC, "R2 word2");
        wr(2'd2, 32'h0);
    endtask

    task automatic t_basic;
        wr(2'd0, lens(3, 2));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        check(pwm_out[0] === 1'b1, "R7 start high", pwm_out[0], 1);
        run_check(0, 3, 2, "R3 hi3 lo2");
        check(pwm_out[1] === 1'b0, "R11 idle channel B low", pwm_out[1], 0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_start_phase;
        int h;
        wr(2'd0, lens(4, 3));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        h = 0;
        while (pwm_out[0] === 1'b1 && h < GUARD) begin h++; @(negedge clk); end
        check(h == 4, "R7 first high full length", h, 4);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_prescale;
        wr(2'd0, lens(3, 2));
        wr(2'd2, ctl(1, 1, 2, 0, 0, 0, 0, 0));
        run_check(0, 9, 6, "R4 divide by 3");
        wr(2'd2, 32'h0);
    endtask

    task automatic t_select;
        wr(2'd2, ctl(1, 1, 0, 1, 0, 0, 0, 0));
        run_check(0, 6, 4, "R5 source 1");
        wr(2'd2, 32'h0);
        wr(2'd2, ctl(1, 1, 0, 2, 0, 0, 0, 0));
        run_check(0, 9, 6, "R5 source 2");
        wr(2'd2, 32'h0);
        wr(2'd2, ctl(1, 1, 0, 3, 0, 0, 0, 0));
        hold_check(0, 1'b1, 40, "R5 silent source holds");
        wr(2'd2, 32'h0);
    endtask

    task automatic t_gate;
        wr(2'd2, ctl(1, 0, 0, 0, 0, 0, 0, 0));
        hold_check(0, 1'b1, 40, "R6 gate clear holds");
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        run_check(0, 3, 2, "R6 gate set runs");
        wr(2'd2, 32'h0);
    endtask

    task automatic t_stop;
        int g;
        wr(2'd0, lens(20, 20));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        check(pwm_out[0] === 1'b1, "R8 mid high before stop", pwm_out[0], 1);
        wr(2'd2, 32'h0);
        check(pwm_out[0] === 1'b0, "R8 stop forces low", pwm_out[0], 0);
        g = 0;
        hold_check(0, 1'b0, 10, "R8 stays low");
    endtask

    task automatic t_zero;
        wr(2'd0, lens(0, 5));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        hold_check(0, 1'b0, 40, "R9 zero high low");
        wr(2'd2, 32'h0);
        wr(2'd0, lens(4, 0));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        hold_check(0, 1'b1, 40, "R9 zero low high");
        wr(2'd2, 32'h0);
        wr(2'd0, lens(0, 0));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        hold_check(0, 1'b0, 40, "R9 both zero low");
        wr(2'd2, 32'h0);
    endtask

    task automatic t_boundary;
        int g, r1, r2, r3;
        wr(2'd0, lens(3, 2));
        wr(2'd2, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        g = 0;
        while (pwm_out[0] !== 1'b0 && g < GUARD) begin @(negedge clk); g++; end
        while (pwm_out[0] !== 1'b1 && g < GUARD) begin @(negedge clk); g++; end
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = lens(6, 4);
        r1 = 1;
        @(negedge clk);
        bus_wr = 1'b0;
        while (pwm_out[0] === 1'b1 && g < GUARD) begin r1++; @(negedge clk); g++; end
        r2 = 0;
        while (pwm_out[0] === 1'b0 && g < GUARD) begin r2++; @(negedge clk); g++; end
        r3 = 0;
        while (pwm_out[0] === 1'b1 && g < GUARD) begin r3++; @(negedge clk); g++; end
        check(r1 == 3, "R10 current high kept", r1, 3);
        check(r2 == 4, "R10 new low next", r2, 4);
        check(r3 == 6, "R10 new high next", r3, 6);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_two_channels;
        wr(2'd0, lens(5, 2));
        wr(2'd1, lens(2, 5));
        wr(2'd2, ctl(1, 1, 0, 0, 1, 1, 1, 0));
        run_check(0, 5, 2, "R11 channel A swapped");
        run_check(1, 4, 10, "R11 channel B own fields");
        wr(2'd2, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_basic();
        t_start_phase();
        t_prescale();
        t_select();
        t_gate();
        t_stop();
        t_zero();
        t_boundary();
        t_two_channels();
        finish_up();
    end

endmodule